// File: doc/BRIEF.md
# Circular trace capture buffer

The block records a stream of 32-bit trace words into an internal RAM that is used as a ring. Once armed, every valid input word is written at the write pointer, which advances modulo the depth; when the pointer rolls over, a wrap flag marks that the ring is full. From then on, the oldest word sits at the write pointer.

Capture ends in one of four ways. Software can write zero to the control register. A trigger pulse can be followed by a programmed number of further words. A manual flush can be raised with stop-on-flush set. A trigger can also raise that flush by itself. After capture ends, the read pointer is placed on the oldest word. Software then pops the words in age order through a read-data register. When nothing is left, that register returns all ones.

A small register bus with single-cycle write strobes reaches the block. Read data appears one cycle after the read strobe. Frame formatting, pass-through FIFO operation and writes to external memory are not part of this block.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset the block is not capturing. Status (offset 0x08) reads 0x4: bit 2 ready, bit 1 triggered, bit 0 wrapped. Both pointers read 0. The depth register (0x0C) reads DEPTH. Register read data appears on the cycle after `reg_rd_i`.
- R2: Writing 1 to bit 0 of control (0x00) while the block is idle and mode (0x04) is 0 (circular) arms capture. Arming clears the write pointer, the wrap flag and the trigger flag. Control bit 0 then reads 1 while capturing. If the mode is 1 (software FIFO) or 2 (hardware FIFO), the enable write has no effect.
- R3: While the block is capturing, each cycle with `trace_valid_i` high stores `trace_data_i` at the write pointer (0x18), and the pointer increments modulo DEPTH. Words offered while the block is not capturing are not stored.
- R4: A store at pointer DEPTH-1 sets status bit 0 (wrapped). The bit stays set until the next arm.
- R5: A `trig_i` pulse is accepted only when capture is running, trigger-on-input (flush control 0x20 bit 8) is set and no trigger has been recorded yet. An accepted pulse sets status bit 1.
- R6: After an accepted trigger with trigger count (0x1C) equal to N > 0, exactly N more words are stored and capture then stops. With N = 0, capture stops on the trigger edge. A word offered in the trigger cycle is always stored and is not counted.
- R7: Writing 1 to flush control bit 6 starts a flush. The bit reads back 0 again from the cycle after the next edge. If bit 12 (stop on flush) is set, capture stops when the flush completes. If bit 5 is set, an accepted trigger starts a flush.
- R8: Writing 0 to control bit 0 stops capture. At any stop, status bit 2 rises. The read pointer (0x14) becomes the write pointer if the ring wrapped, and 0 if it did not.
- R9: Once capture has stopped, each read of 0x10 returns the next stored word, oldest first, and advances the read pointer. After the last stored word, reads return 0xFFFFFFFF and the read pointer holds.
- R10: A read of 0x10 while capture is running returns 0xFFFFFFFF and moves no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_valid_i | input | 1 | Trace word valid |
| trace_data_i | input | 32 | Trace word |
| trig_i | input | 1 | Single-cycle trigger pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |

## Verification
Several rules are checked by assertions on every cycle:
- the write pointer and the trigger flag are frozen while the block is idle;
- a flush request clears one edge after it is raised;
- the post-trigger count ends capture on the cycle it reaches zero;
- the read pointer lands on the oldest word when capture falls;
- an empty or still-running drain returns the sentinel without moving any pointer.

Only the bench scenarios can show the rest:
- the stored contents and their age order across a wrap;
- the exact number of words kept after a trigger;
- that enable writes in a non-circular mode and triggers without trigger-on-input leave the block untouched.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DEPTH = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RDATA = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RPTR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_WPTR  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TCNT  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_FLUSH = 8'h20;

  localparam int FB_FLUSH_ON_TRIG = 5;
  localparam int FB_FLUSH_REQ     = 6;
  localparam int FB_TRIG_IN_EN    = 8;
  localparam int FB_STOP_ON_FLUSH = 12;

  typedef enum logic [1:0] {
    MODE_RING    = 2'd0,
    MODE_SW_FIFO = 2'd1,
    MODE_HW_FIFO = 2'd2
  } cap_mode_e;

  typedef struct packed {
    logic flush_on_trig;
    logic trig_in_en;
    logic stop_on_flush;
  } flush_cfg_t;
endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trb_ctrl.sv
module trb_ctrl
  import trb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              trig_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              flush_wr_i,
  input  logic              pop_i,
  input  cap_mode_e         mode_i,
  input  flush_cfg_t        cfg_i,
  input  logic [CNT_W-1:0]  tcnt_i,
  output logic              we_o,
  output logic [AW-1:0]     wptr_o,
  output logic [AW-1:0]     rptr_o,
  output logic              capturing_o,
  output logic              wrapped_o,
  output logic              triggered_o,
  output logic              flush_pend_o,
  output logic              avail_o
);
  logic             cap_q, wrap_q, trig_q, flush_q, avail_q;
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  logic          store, trig_acc, arm_ok, flush_set, stop;
  logic          wrap_n;
  logic [AW-1:0] wptr_n, rptr_inc;

  assign store     = cap_q && valid_i;
  assign trig_acc  = cap_q && !trig_q && cfg_i.trig_in_en && trig_i;
  assign arm_ok    = arm_i && !cap_q && (mode_i == MODE_RING);
  assign flush_set = flush_wr_i || (trig_acc && cfg_i.flush_on_trig);
  assign wptr_n    = store ? wptr_q + AW'(1) : wptr_q;
  assign wrap_n    = wrap_q || (store && (wptr_q == AW'(DEPTH-1)));
  assign rptr_inc  = rptr_q + AW'(1);

  assign stop = cap_q && (
                  disarm_i ||
                  (trig_q && store && (cnt_q == CNT_W'(1))) ||
                  (trig_acc && (tcnt_i == '0)) ||
                  (flush_q && cfg_i.stop_on_flush));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= 1'b0;
      wrap_q  <= 1'b0;
      trig_q  <= 1'b0;
      flush_q <= 1'b0;
      avail_q <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (flush_set)    flush_q <= 1'b1;
      else if (flush_q) flush_q <= 1'b0;

      if (arm_ok) begin
        cap_q   <= 1'b1;
        wrap_q  <= 1'b0;
        trig_q  <= 1'b0;
        avail_q <= 1'b0;
        wptr_q  <= '0;
        rptr_q  <= '0;
      end else if (cap_q) begin
        wptr_q <= wptr_n;
        wrap_q <= wrap_n;
        if (trig_acc) begin
          trig_q <= 1'b1;
          cnt_q  <= tcnt_i;
        end else if (trig_q && store) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        if (stop) begin
          cap_q   <= 1'b0;
          rptr_q  <= wrap_n ? wptr_n : '0;
          avail_q <= wrap_n || (wptr_n != '0);
        end
      end else if (pop_i && avail_q) begin
        rptr_q  <= rptr_inc;
        avail_q <= (rptr_inc != wptr_q);
      end
    end
  end

  assign we_o         = store;
  assign wptr_o       = wptr_q;
  assign rptr_o       = rptr_q;
  assign capturing_o  = cap_q;
  assign wrapped_o    = wrap_q;
  assign triggered_o  = trig_q;
  assign flush_pend_o = flush_q;
  assign avail_o      = avail_q && !cap_q;

  p_idle_wptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_q && !arm_ok) |=> $stable(wptr_q));

  p_idle_trig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_q && !arm_ok) |=> $stable(trig_q));

  p_stop_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && trig_q && store && cnt_q == CNT_W'(1)) |=> !cap_q);

  p_flush_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && !flush_set) |=> !flush_q);

  p_rptr_on_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cap_q) |-> (rptr_q == (wrap_q ? wptr_q : '0)));

  p_empty_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !avail_q && !arm_ok) |=> $stable(rptr_q));
endmodule

// File: rtl/trb_regs.sv
module trb_regs
  import trb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              arm_o,
  output logic              disarm_o,
  output logic              flush_wr_o,
  output logic              pop_o,
  output cap_mode_e         mode_o,
  output flush_cfg_t        cfg_o,
  output logic [CNT_W-1:0]  tcnt_o,
  input  logic [AW-1:0]     wptr_i,
  input  logic [AW-1:0]     rptr_i,
  input  logic              capturing_i,
  input  logic              wrapped_i,
  input  logic              triggered_i,
  input  logic              flush_pend_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  cap_mode_e         mode_q;
  flush_cfg_t        cfg_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;

  logic wr_ctrl, wr_flush;
  assign wr_ctrl    = reg_wr_i && (reg_addr_i == OFS_CTRL);
  assign wr_flush   = reg_wr_i && (reg_addr_i == OFS_FLUSH);
  assign arm_o      = wr_ctrl && reg_wdata_i[0];
  assign disarm_o   = wr_ctrl && !reg_wdata_i[0];
  assign flush_wr_o = wr_flush && reg_wdata_i[FB_FLUSH_REQ];
  assign pop_o      = reg_rd_i && (reg_addr_i == OFS_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RING;
      cfg_q  <= '0;
      tcnt_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        OFS_MODE: mode_q <= cap_mode_e'(reg_wdata_i[1:0]);
        OFS_TCNT: tcnt_q <= reg_wdata_i[CNT_W-1:0];
        OFS_FLUSH: begin
          cfg_q.flush_on_trig <= reg_wdata_i[FB_FLUSH_ON_TRIG];
          cfg_q.trig_in_en    <= reg_wdata_i[FB_TRIG_IN_EN];
          cfg_q.stop_on_flush <= reg_wdata_i[FB_STOP_ON_FLUSH];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      OFS_CTRL:  rd_mux[0] = capturing_i;
      OFS_MODE:  rd_mux[1:0] = mode_q;
      OFS_STAT:  rd_mux[2:0] = {!capturing_i, triggered_i, wrapped_i};
      OFS_DEPTH: rd_mux = DATA_W'(DEPTH);
      OFS_RDATA: rd_mux = avail_i ? ram_rdata_i : '1;
      OFS_RPTR:  rd_mux[AW-1:0] = rptr_i;
      OFS_WPTR:  rd_mux[AW-1:0] = wptr_i;
      OFS_TCNT:  rd_mux[CNT_W-1:0] = tcnt_q;
      OFS_FLUSH: begin
        rd_mux[FB_FLUSH_ON_TRIG] = cfg_q.flush_on_trig;
        rd_mux[FB_FLUSH_REQ]     = flush_pend_i;
        rd_mux[FB_TRIG_IN_EN]    = cfg_q.trig_in_en;
        rd_mux[FB_STOP_ON_FLUSH] = cfg_q.stop_on_flush;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign mode_o      = mode_q;
  assign cfg_o       = cfg_q;
  assign tcnt_o      = tcnt_q;

  p_busy_sentinel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && capturing_i) |=> (reg_rdata_o == '1));
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
  import trb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_valid_i,
  input  logic [31:0]       trace_data_i,
  input  logic              trig_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  logic             arm, disarm, flush_wr, pop, we;
  logic             capturing, wrapped, triggered, flush_pend, avail;
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] tcnt;
  logic [DATA_W-1:0] ram_rdata;
  cap_mode_e        mode;
  flush_cfg_t       cfg;

  trb_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o,
    .arm_o(arm), .disarm_o(disarm), .flush_wr_o(flush_wr), .pop_o(pop),
    .mode_o(mode), .cfg_o(cfg), .tcnt_o(tcnt),
    .wptr_i(wptr), .rptr_i(rptr), .capturing_i(capturing),
    .wrapped_i(wrapped), .triggered_i(triggered), .flush_pend_i(flush_pend),
    .avail_i(avail), .ram_rdata_i(ram_rdata)
  );

  trb_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .valid_i(trace_valid_i), .trig_i,
    .arm_i(arm), .disarm_i(disarm), .flush_wr_i(flush_wr), .pop_i(pop),
    .mode_i(mode), .cfg_i(cfg), .tcnt_i(tcnt),
    .we_o(we), .wptr_o(wptr), .rptr_o(rptr), .capturing_o(capturing),
    .wrapped_o(wrapped), .triggered_o(triggered), .flush_pend_o(flush_pend),
    .avail_o(avail)
  );

  trb_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_ram (
    .clk_i, .we_i(we), .waddr_i(wptr), .wdata_i(trace_data_i),
    .raddr_i(rptr), .rdata_o(ram_rdata)
  );
endmodule

// File: tb/trace_ring_buf_tb.sv
module trace_ring_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic valid = 0, trig = 0, wr = 0, rd = 0;
  logic [31:0] data = 0, wdata = 0, rdata;
  logic [7:0] addr = 0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_mem [DEPTH];
  int m_wptr, m_cnt, cfg_cnt;
  bit m_wrap, m_capt, m_trig, m_post, cfg_tin;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ring_buf #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trace_valid_i(valid), .trace_data_i(data),
    .trig_i(trig), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic expect_reg(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    check(req, d, exp);
  endtask

  function automatic int exp_rptr();
    return m_wrap ? m_wptr : 0;
  endfunction

  function automatic int exp_count();
    return m_wrap ? DEPTH : m_wptr;
  endfunction

  function automatic logic [31:0] exp_status();
    return {29'd0, !m_capt, m_trig, m_wrap};
  endfunction

  task automatic cycle(bit v, logic [31:0] d, bit t);
    bit acc;
    @(negedge clk); valid = v; data = d; trig = t;
    @(negedge clk); valid = 0; trig = 0;
    if (m_capt) begin
      acc = t && !m_trig && cfg_tin;
      if (v) begin
        m_mem[m_wptr] = d;
        if (m_wptr == DEPTH-1) m_wrap = 1;
        m_wptr = (m_wptr + 1) % DEPTH;
        if (m_post) begin
          m_cnt--;
          if (m_cnt == 0) m_capt = 0;
        end
      end
      if (acc) begin
        m_trig = 1;
        if (cfg_cnt == 0) m_capt = 0;
        else begin m_post = 1; m_cnt = cfg_cnt; end
      end
    end
  endtask

  task automatic arm();
    reg_write(8'h00, 1);
    m_capt = 1; m_wptr = 0; m_wrap = 0; m_trig = 0; m_post = 0;
  endtask

  task automatic set_cfg(bit fot, bit tin, bit sof, int cnt);
    cfg_tin = tin; cfg_cnt = cnt;
    reg_write(8'h1C, cnt);
    reg_write(8'h20, (32'(fot) << 5) | (32'(tin) << 8) | (32'(sof) << 12));
  endtask

  task automatic drain(string req);
    logic [31:0] d;
    int n, s;
    n = exp_count(); s = exp_rptr();
    expect_reg("R8 rptr at stop", 8'h14, s);
    for (int i = 0; i < n; i++) begin
      reg_read(8'h10, d);
      check(req, d, m_mem[(s + i) % DEPTH]);
    end
    expect_reg("R9 sentinel when empty", 8'h10, 32'hFFFF_FFFF);
    expect_reg("R9 rptr holds when empty", 8'h14, m_wptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    expect_reg("R1 status", 8'h08, 32'h4);
    expect_reg("R1 ctrl", 8'h00, 0);
    expect_reg("R1 wptr", 8'h18, 0);
    expect_reg("R1 rptr", 8'h14, 0);
    expect_reg("R1 depth", 8'h0C, DEPTH);
    expect_reg("R9 empty after reset", 8'h10, 32'hFFFF_FFFF);

    // R2 enable ignored outside ring mode
    reg_write(8'h04, 1);
    reg_write(8'h00, 1);
    expect_reg("R2 sw fifo mode no arm", 8'h00, 0);
    reg_write(8'h04, 2);
    reg_write(8'h00, 1);
    expect_reg("R2 hw fifo mode no arm", 8'h00, 0);
    reg_write(8'h04, 0);

    // R3 word offered while idle is dropped
    cycle(1, 32'hDEAD_0001, 0);
    expect_reg("R3 idle store dropped", 8'h18, 0);

    // R5 trigger ignored without trigger-on-input
    set_cfg(0, 0, 0, 3);
    arm();
    expect_reg("R2 ctrl reads armed", 8'h00, 1);
    cycle(1, $urandom, 1);
    expect_reg("R5 trigger ignored when disabled", 8'h08, exp_status());

    // R10 read while capturing
    for (int i = 0; i < 4; i++) cycle(1, $urandom, 0);
    expect_reg("R10 busy read sentinel", 8'h10, 32'hFFFF_FFFF);
    expect_reg("R3 wptr", 8'h18, m_wptr);
    reg_write(8'h00, 0); m_capt = 0;
    expect_reg("R8 status after sw stop", 8'h08, exp_status());
    cycle(1, 32'hBAD0_BAD0, 0);
    drain("R9 drain order unwrapped");

    // R6 post-trigger count 3
    set_cfg(0, 1, 0, 3);
    arm();
    for (int i = 0; i < 4; i++) cycle(1, $urandom, 0);
    cycle(0, 0, 1);
    expect_reg("R5 triggered set", 8'h08, exp_status());
    for (int i = 0; i < 3; i++) cycle(1, $urandom, 0);
    expect_reg("R6 stopped after count", 8'h00, 0);
    cycle(1, $urandom, 0);
    expect_reg("R6 wptr after count", 8'h18, 7);
    drain("R6 drain after trigger stop");

    // R4 wrap with random gaps and random trigger
    set_cfg(0, 1, 0, 2);
    arm();
    for (int i = 0; i < 24; i++) cycle(($urandom % 4) != 0, $urandom, 0);
    for (int i = 0; i < 8; i++) cycle(1, $urandom, (i == 1));
    for (int i = 0; i < 4; i++) cycle(1, $urandom, 0);
    expect_reg("R4 status wrapped", 8'h08, exp_status());
    expect_reg("R6 wptr after wrap", 8'h18, m_wptr);
    drain("R4 drain oldest first after wrap");

    // R6 zero count: trigger-cycle word kept
    set_cfg(0, 1, 0, 0);
    arm();
    cycle(1, 32'h1111_1111, 0);
    cycle(1, 32'h2222_2222, 1);
    cycle(1, 32'h3333_3333, 0);
    expect_reg("R6 zero count wptr", 8'h18, 2);
    drain("R6 zero count drain");

    // R7 manual flush without stop
    set_cfg(0, 0, 0, 5);
    arm();
    reg_write(8'h20, 32'h40);
    cycle(0, 0, 0);
    expect_reg("R7 flush req self-clears", 8'h20, 0);
    expect_reg("R7 flush without stop keeps capture", 8'h00, 1);

    // R7 manual flush with stop
    reg_write(8'h20, 32'h1000 | 32'h40);
    cycle(1, $urandom, 0);
    m_capt = 0;
    expect_reg("R7 stop on flush", 8'h00, 0);
    expect_reg("R7 cfg readback", 8'h20, 32'h1000);

    // R7 flush on trigger
    set_cfg(1, 1, 1, 10);
    arm();
    cycle(1, $urandom, 0);
    cycle(0, 0, 1);
    cycle(0, 0, 0);
    expect_reg("R7 flush on trigger stops", 8'h00, 0);
    expect_reg("R7 triggered status", 8'h08, 32'h6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule